// File: doc/BRIEF.md
# Receive Descriptor Ring Manager

This block is the hardware half of a receive buffer-descriptor ring that sits behind an Ethernet MAC receive path. Frames arrive as a byte stream with an end-of-frame marker. On the last byte, three error flags are also sampled. For each frame the block reads the descriptor at its current ring index from a small on-block descriptor store. If hardware owns that descriptor, the block writes the frame bytes to the buffer the descriptor points at. It then writes back the byte count and a status word, hands the descriptor to software, and moves to the next ring slot.

Ownership is carried by an EMPTY bit in each descriptor's status word. The ring ends at whichever descriptor has its WRAP bit set, not at a fixed count. The length written back includes the 4-byte frame check sequence. A completion pulse reports the slot, status, length and an accept flag that applies the usual software acceptance rule.

Software fills and re-arms descriptors through a simple write port, and reads them back through a read port. A kick input tells the block that fresh buffers are available. If a frame arrives while the current slot is still held by software, the frame is discarded and a sticky no-buffer event is raised.

Top module: `rx_desc_ring`

## Requirements
- R1: After reset every descriptor reads back as all zeros, the ring index is 0, and `buf_we`, `frame_done` and `nobuf_evt` are low.
- R2: When a frame ends in a descriptor whose EMPTY bit (status bit 15) is set, that descriptor's status becomes LAST (bit 11) plus its old WRAP bit (bit 13) plus the error bits, with EMPTY cleared. Its length field gets the stored byte count. In the next cycle `frame_done` pulses once, carrying the slot index, that status and that length.
- R3: Each accepted byte appears on `buf_we`/`buf_addr`/`buf_data` one cycle after it is sampled. Its address is the descriptor's buffer address plus the byte's offset in the frame. Bytes are written only into a descriptor that was EMPTY when the frame's first byte arrived.
- R4: After completing a descriptor whose WRAP bit is clear, the ring index advances by one, modulo the ring size.
- R5: After completing a descriptor whose WRAP bit is set, the next frame uses slot 0.
- R6: The written length counts the 4 FCS bytes. `done_ok` is high only when LAST is set, no error bit is set, and the length minus 4 is greater than 14 (length of at least 19).
- R7: The end-of-frame error inputs map to status bits as follows: CRC error to bit 2, non-octet alignment to bit 4, receiver overrun to bit 1.
- R8: A frame longer than the descriptor's length field (the buffer capacity) stores only capacity bytes, writes back length equal to the capacity, and sets the truncation bit (bit 0).
- R9: A frame longer than MAX_FRAME (default 1518) bytes sets the overlong bit (bit 5).
- R10: A frame whose first byte meets a descriptor without EMPTY is dropped: no buffer writes, no `frame_done`, and the ring index stays put. `nobuf_evt` rises and stays high until `sw_kick`.
- R11: A software write stores status, length and address in the indexed descriptor. The read port returns those fields combinationally for `sw_rd_idx`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| rx_valid | input | 1 | Receive byte valid |
| rx_data | input | 8 | Receive byte |
| rx_eof | input | 1 | Byte is the last of the frame |
| rx_err_crc | input | 1 | CRC error, sampled with rx_eof |
| rx_err_align | input | 1 | Non-octet-aligned frame, sampled with rx_eof |
| rx_err_ovr | input | 1 | Receive overrun, sampled with rx_eof |
| sw_we | input | 1 | Software descriptor write strobe |
| sw_idx | input | IDX_W | Descriptor index to write |
| sw_status | input | 16 | Status word to write |
| sw_len | input | 16 | Length (buffer capacity) to write |
| sw_addr | input | 32 | Buffer address to write |
| sw_kick | input | 1 | Buffers re-armed; clears the no-buffer event |
| sw_rd_idx | input | IDX_W | Descriptor index to read |
| sw_rd_status | output | 16 | Status word of the read descriptor |
| sw_rd_len | output | 16 | Length field of the read descriptor |
| sw_rd_addr | output | 32 | Buffer address of the read descriptor |
| buf_we | output | 1 | Buffer byte write strobe |
| buf_addr | output | 32 | Buffer byte address |
| buf_data | output | 8 | Buffer byte data |
| frame_done | output | 1 | One-cycle frame completion pulse |
| done_idx | output | IDX_W | Slot that was completed |
| done_status | output | 16 | Status written back |
| done_len | output | 16 | Length written back |
| done_ok | output | 1 | Frame passes the acceptance rule |
| nobuf_evt | output | 1 | Sticky frame-dropped-for-lack-of-buffer event |

## Verification
A wrong ring index shows up as a wrong `buf_addr` on the next frame's first byte, one cycle after that byte. A lost or spurious ownership hand-off shows up either as a `frame_done` on a slot software has not re-armed, or as a missing completion on a slot it has. A miscounted byte offset corrupts `buf_addr` on the very byte where it goes wrong. A bad status encoding is visible on `done_status` in the cycle after the last byte, and again through the read port. The bench keeps its own descriptor model and ring index. It predicts every buffer write and every completion, so any divergence is reported at the first output that differs.

// File: rtl/rxr_pkg.sv
package rxr_pkg;

   localparam int STAT_W = 16;
   localparam int LEN_W  = 16;
   localparam int BADR_W = 32;

   // status word bit positions (software decodes these)
   localparam int BIT_EMPTY = 15;
   localparam int BIT_WRAP  = 13;
   localparam int BIT_LAST  = 11;
   localparam int BIT_LONG  = 5;
   localparam int BIT_ALIGN = 4;
   localparam int BIT_CRC   = 2;
   localparam int BIT_OVR   = 1;
   localparam int BIT_TRUNC = 0;

   typedef struct packed {
      logic [STAT_W-1:0] status;
      logic [LEN_W-1:0]  len;
      logic [BADR_W-1:0] addr;
   } desc_t;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_RECV = 2'd1,
      ST_DROP = 2'd2
   } rx_state_t;

endpackage

// File: rtl/rxr_desc_store.sv
module rxr_desc_store
   import rxr_pkg::*;
#(
   parameter int NUM_DESC = 4,
   parameter int IDX_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sw_we,
   input  logic [IDX_W-1:0]  sw_idx,
   input  desc_t             sw_desc,
   input  logic              hw_we,
   input  logic [IDX_W-1:0]  hw_idx,
   input  logic [STAT_W-1:0] hw_status,
   input  logic [LEN_W-1:0]  hw_len,
   input  logic [IDX_W-1:0]  hw_rd_idx,
   output desc_t             hw_rd,
   input  logic [IDX_W-1:0]  sw_rd_idx,
   output desc_t             sw_rd
);

   logic [STAT_W-1:0] st_q   [NUM_DESC];
   logic [LEN_W-1:0]  len_q  [NUM_DESC];
   logic [BADR_W-1:0] addr_q [NUM_DESC];

   for (genvar g = 0; g < NUM_DESC; g++) begin : g_ent
      logic [STAT_W-1:0] st_r;
      logic [LEN_W-1:0]  len_r;
      logic [BADR_W-1:0] addr_r;
      logic              hw_hit;
      logic              sw_hit;

      assign hw_hit = hw_we && (hw_idx == IDX_W'(g));
      assign sw_hit = sw_we && (sw_idx == IDX_W'(g));

      // hardware write-back wins over a same-cycle software write
      always_ff @(posedge clk) begin
         if (!rst_n) begin
            st_r   <= '0;
            len_r  <= '0;
            addr_r <= '0;
         end else if (hw_hit) begin
            st_r  <= hw_status;
            len_r <= hw_len;
         end else if (sw_hit) begin
            st_r   <= sw_desc.status;
            len_r  <= sw_desc.len;
            addr_r <= sw_desc.addr;
         end
      end

      assign st_q[g]   = st_r;
      assign len_q[g]  = len_r;
      assign addr_q[g] = addr_r;
   end

   always_comb begin
      hw_rd = '0;
      if (int'(hw_rd_idx) < NUM_DESC) begin
         hw_rd.status = st_q[hw_rd_idx];
         hw_rd.len    = len_q[hw_rd_idx];
         hw_rd.addr   = addr_q[hw_rd_idx];
      end
   end

   always_comb begin
      sw_rd = '0;
      if (int'(sw_rd_idx) < NUM_DESC) begin
         sw_rd.status = st_q[sw_rd_idx];
         sw_rd.len    = len_q[sw_rd_idx];
         sw_rd.addr   = addr_q[sw_rd_idx];
      end
   end

   // R2: a hand-off leaves the slot owned by software
   assert_handoff_clears_empty_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (hw_we && (int'(hw_idx) < NUM_DESC)) |=> !st_q[$past(hw_idx)][BIT_EMPTY]);

endmodule

// File: rtl/rxr_status_enc.sv
module rxr_status_enc
   import rxr_pkg::*;
#(
   parameter int MAX_FRAME = 1518,
   parameter int FCS_BYTES = 4,
   parameter int MIN_HDR   = 14
) (
   input  logic [LEN_W-1:0]  total,
   input  logic [LEN_W-1:0]  cap,
   input  logic              wrap,
   input  logic              err_crc,
   input  logic              err_align,
   input  logic              err_ovr,
   output logic [STAT_W-1:0] status,
   output logic [LEN_W-1:0]  len,
   output logic              ok
);

   localparam logic [LEN_W-1:0] MAX_L    = LEN_W'(MAX_FRAME);
   localparam logic [LEN_W-1:0] ACCEPT_L = LEN_W'(FCS_BYTES + MIN_HDR);

   if (MAX_FRAME >= (1 << LEN_W)) begin : g_bad_max
      $error("MAX_FRAME does not fit the length field");
   end

   logic trunc;
   logic too_long;
   logic any_err;

   always_comb begin
      trunc    = total > cap;
      too_long = total > MAX_L;
      len      = trunc ? cap : total;
      status   = '0;
      status[BIT_WRAP]  = wrap;
      status[BIT_LAST]  = 1'b1;
      status[BIT_LONG]  = too_long;
      status[BIT_ALIGN] = err_align;
      status[BIT_CRC]   = err_crc;
      status[BIT_OVR]   = err_ovr;
      status[BIT_TRUNC] = trunc;
      any_err = too_long | err_align | err_crc | err_ovr | trunc;
      ok      = status[BIT_LAST] && !any_err && (len > ACCEPT_L);
   end

endmodule

// File: rtl/rxr_frame_ctl.sv
module rxr_frame_ctl
   import rxr_pkg::*;
#(
   parameter int NUM_DESC = 4,
   parameter int IDX_W    = 2
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_eof,
   input  logic              sw_kick,
   input  desc_t             cur_desc,
   input  logic [STAT_W-1:0] enc_status,
   input  logic [LEN_W-1:0]  enc_len,
   input  logic              enc_ok,
   output logic [IDX_W-1:0]  cur_idx,
   output logic              wb_fire,
   output logic [LEN_W-1:0]  wb_total,
   output logic [LEN_W-1:0]  wb_cap,
   output logic              wb_wrap,
   output logic              buf_we,
   output logic [BADR_W-1:0] buf_addr,
   output logic [7:0]        buf_data,
   output logic              nobuf_evt,
   output logic              frame_done,
   output logic [IDX_W-1:0]  done_idx,
   output logic [STAT_W-1:0] done_status,
   output logic [LEN_W-1:0]  done_len,
   output logic              done_ok
);

   localparam logic [IDX_W-1:0] LAST_IDX = IDX_W'(NUM_DESC - 1);

   rx_state_t         state_q;
   logic [LEN_W-1:0]  cnt_q;
   logic [LEN_W-1:0]  cap_q;
   logic [BADR_W-1:0] base_q;
   logic              wrap_q;

   logic              is_idle;
   logic              owned;
   logic [LEN_W-1:0]  eff_cnt;
   logic [LEN_W-1:0]  eff_cap;
   logic [BADR_W-1:0] eff_base;
   logic              eff_wrap;
   logic              take;
   logic              drop_start;
   logic              store_byte;
   logic [LEN_W-1:0]  cnt_inc;

   always_comb begin
      is_idle    = (state_q == ST_IDLE);
      owned      = cur_desc.status[BIT_EMPTY];
      eff_cnt    = is_idle ? '0 : cnt_q;
      eff_cap    = is_idle ? cur_desc.len : cap_q;
      eff_base   = is_idle ? cur_desc.addr : base_q;
      eff_wrap   = is_idle ? cur_desc.status[BIT_WRAP] : wrap_q;
      take       = rx_valid && (is_idle ? owned : (state_q == ST_RECV));
      drop_start = rx_valid && is_idle && !owned;
      store_byte = take && (eff_cnt < eff_cap);
      cnt_inc    = (&eff_cnt) ? eff_cnt : eff_cnt + LEN_W'(1);
      wb_fire    = take && rx_eof;
      wb_total   = cnt_inc;
      wb_cap     = eff_cap;
      wb_wrap    = eff_wrap;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         cap_q   <= '0;
         base_q  <= '0;
         wrap_q  <= 1'b0;
      end else begin
         if (take) begin
            cnt_q   <= cnt_inc;
            state_q <= rx_eof ? ST_IDLE : ST_RECV;
            if (is_idle) begin
               cap_q  <= cur_desc.len;
               base_q <= cur_desc.addr;
               wrap_q <= cur_desc.status[BIT_WRAP];
            end
         end else if (drop_start) begin
            state_q <= rx_eof ? ST_IDLE : ST_DROP;
         end else if (state_q == ST_DROP && rx_valid && rx_eof) begin
            state_q <= ST_IDLE;
         end
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cur_idx <= '0;
      end else if (wb_fire) begin
         cur_idx <= (eff_wrap || cur_idx == LAST_IDX) ? '0 : cur_idx + IDX_W'(1);
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         buf_we   <= 1'b0;
         buf_addr <= '0;
         buf_data <= '0;
      end else begin
         buf_we   <= store_byte;
         buf_addr <= eff_base + BADR_W'(eff_cnt);
         buf_data <= rx_data;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         nobuf_evt <= 1'b0;
      end else if (drop_start) begin
         nobuf_evt <= 1'b1;
      end else if (sw_kick) begin
         nobuf_evt <= 1'b0;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         frame_done  <= 1'b0;
         done_idx    <= '0;
         done_status <= '0;
         done_len    <= '0;
         done_ok     <= 1'b0;
      end else begin
         frame_done <= wb_fire;
         if (wb_fire) begin
            done_idx    <= cur_idx;
            done_status <= enc_status;
            done_len    <= enc_len;
            done_ok     <= enc_ok;
         end
      end
   end

   // R10: a frame meeting a software-owned slot stores nothing
   assert_no_store_unowned_R10: assert property (@(posedge clk) disable iff (!rst_n)
      drop_start |=> !buf_we);

   // R10: a dropped frame leaves the ring index where it was
   assert_drop_holds_index_R10: assert property (@(posedge clk) disable iff (!rst_n)
      drop_start |=> $stable(cur_idx));

   // R10: the no-buffer event stays until kicked
   assert_nobuf_sticky_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (nobuf_evt && !sw_kick) |=> nobuf_evt);

   // R5: a WRAP slot sends the ring back to slot 0
   assert_wrap_to_zero_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (wb_fire && eff_wrap) |=> (cur_idx == '0));

   // R2: each completion is a single-cycle pulse
   assert_done_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (frame_done && !$past(wb_fire)) |-> 1'b0);

endmodule

// File: rtl/rx_desc_ring.sv
module rx_desc_ring
   import rxr_pkg::*;
#(
   parameter int NUM_DESC  = 4,
   parameter int MAX_FRAME = 1518,
   parameter int FCS_BYTES = 4,
   parameter int MIN_HDR   = 14,
   localparam int IDX_W    = (NUM_DESC > 1) ? $clog2(NUM_DESC) : 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              rx_valid,
   input  logic [7:0]        rx_data,
   input  logic              rx_eof,
   input  logic              rx_err_crc,
   input  logic              rx_err_align,
   input  logic              rx_err_ovr,
   input  logic              sw_we,
   input  logic [IDX_W-1:0]  sw_idx,
   input  logic [15:0]       sw_status,
   input  logic [15:0]       sw_len,
   input  logic [31:0]       sw_addr,
   input  logic              sw_kick,
   input  logic [IDX_W-1:0]  sw_rd_idx,
   output logic [15:0]       sw_rd_status,
   output logic [15:0]       sw_rd_len,
   output logic [31:0]       sw_rd_addr,
   output logic              buf_we,
   output logic [31:0]       buf_addr,
   output logic [7:0]        buf_data,
   output logic              frame_done,
   output logic [IDX_W-1:0]  done_idx,
   output logic [15:0]       done_status,
   output logic [15:0]       done_len,
   output logic              done_ok,
   output logic              nobuf_evt
);

   if (NUM_DESC < 2) begin : g_bad_ring
      $error("NUM_DESC must be at least 2");
   end
   if (FCS_BYTES < 0 || MIN_HDR < 0) begin : g_bad_accept
      $error("acceptance thresholds must be non-negative");
   end

   desc_t             sw_desc;
   desc_t             cur_desc;
   desc_t             rd_desc;
   logic [IDX_W-1:0]  cur_idx;
   logic              wb_fire;
   logic [LEN_W-1:0]  wb_total;
   logic [LEN_W-1:0]  wb_cap;
   logic              wb_wrap;
   logic [STAT_W-1:0] enc_status;
   logic [LEN_W-1:0]  enc_len;
   logic              enc_ok;

   assign sw_desc = '{status: sw_status, len: sw_len, addr: sw_addr};

   rxr_desc_store #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_store (
      .clk       (clk),
      .rst_n     (rst_n),
      .sw_we     (sw_we),
      .sw_idx    (sw_idx),
      .sw_desc   (sw_desc),
      .hw_we     (wb_fire),
      .hw_idx    (cur_idx),
      .hw_status (enc_status),
      .hw_len    (enc_len),
      .hw_rd_idx (cur_idx),
      .hw_rd     (cur_desc),
      .sw_rd_idx (sw_rd_idx),
      .sw_rd     (rd_desc)
   );

   rxr_status_enc #(.MAX_FRAME(MAX_FRAME), .FCS_BYTES(FCS_BYTES), .MIN_HDR(MIN_HDR)) u_enc (
      .total     (wb_total),
      .cap       (wb_cap),
      .wrap      (wb_wrap),
      .err_crc   (rx_err_crc),
      .err_align (rx_err_align),
      .err_ovr   (rx_err_ovr),
      .status    (enc_status),
      .len       (enc_len),
      .ok        (enc_ok)
   );

   rxr_frame_ctl #(.NUM_DESC(NUM_DESC), .IDX_W(IDX_W)) u_ctl (
      .clk         (clk),
      .rst_n       (rst_n),
      .rx_valid    (rx_valid),
      .rx_data     (rx_data),
      .rx_eof      (rx_eof),
      .sw_kick     (sw_kick),
      .cur_desc    (cur_desc),
      .enc_status  (enc_status),
      .enc_len     (enc_len),
      .enc_ok      (enc_ok),
      .cur_idx     (cur_idx),
      .wb_fire     (wb_fire),
      .wb_total    (wb_total),
      .wb_cap      (wb_cap),
      .wb_wrap     (wb_wrap),
      .buf_we      (buf_we),
      .buf_addr    (buf_addr),
      .buf_data    (buf_data),
      .nobuf_evt   (nobuf_evt),
      .frame_done  (frame_done),
      .done_idx    (done_idx),
      .done_status (done_status),
      .done_len    (done_len),
      .done_ok     (done_ok)
   );

   assign sw_rd_status = rd_desc.status;
   assign sw_rd_len    = rd_desc.len;
   assign sw_rd_addr   = rd_desc.addr;

   // R2: a completed frame always reports LAST and never EMPTY
   assert_done_status_R2: assert property (@(posedge clk) disable iff (!rst_n)
      frame_done |-> (done_status[BIT_LAST] && !done_status[BIT_EMPTY]));

   // R8: the reported length never exceeds the slot's capacity at frame start
   assert_len_within_cap_R8: assert property (@(posedge clk) disable iff (!rst_n)
      wb_fire |=> (done_len <= $past(wb_cap)));

endmodule

// File: tb/test_rx_desc_ring.sv
module test_rx_desc_ring;

   localparam int N = 4;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        rx_valid = 1'b0;
   logic [7:0]  rx_data = '0;
   logic        rx_eof = 1'b0;
   logic        rx_err_crc = 1'b0;
   logic        rx_err_align = 1'b0;
   logic        rx_err_ovr = 1'b0;
   logic        sw_we = 1'b0;
   logic [1:0]  sw_idx = '0;
   logic [15:0] sw_status = '0;
   logic [15:0] sw_len = '0;
   logic [31:0] sw_addr = '0;
   logic        sw_kick = 1'b0;
   logic [1:0]  sw_rd_idx = '0;
   logic [15:0] sw_rd_status;
   logic [15:0] sw_rd_len;
   logic [31:0] sw_rd_addr;
   logic        buf_we;
   logic [31:0] buf_addr;
   logic [7:0]  buf_data;
   logic        frame_done;
   logic [1:0]  done_idx;
   logic [15:0] done_status;
   logic [15:0] done_len;
   logic        done_ok;
   logic        nobuf_evt;

   always #5 clk = ~clk;

   rx_desc_ring #(.NUM_DESC(N)) i_rx_desc_ring (
      .clk(clk), .rst_n(rst_n),
      .rx_valid(rx_valid), .rx_data(rx_data), .rx_eof(rx_eof),
      .rx_err_crc(rx_err_crc), .rx_err_align(rx_err_align), .rx_err_ovr(rx_err_ovr),
      .sw_we(sw_we), .sw_idx(sw_idx), .sw_status(sw_status), .sw_len(sw_len),
      .sw_addr(sw_addr), .sw_kick(sw_kick), .sw_rd_idx(sw_rd_idx),
      .sw_rd_status(sw_rd_status), .sw_rd_len(sw_rd_len), .sw_rd_addr(sw_rd_addr),
      .buf_we(buf_we), .buf_addr(buf_addr), .buf_data(buf_data),
      .frame_done(frame_done), .done_idx(done_idx), .done_status(done_status),
      .done_len(done_len), .done_ok(done_ok), .nobuf_evt(nobuf_evt)
   );

   typedef struct packed {
      logic [31:0] a;
      logic [7:0]  d;
   } wr_t;

   typedef struct packed {
      logic [1:0]  idx;
      logic [15:0] st;
      logic [15:0] len;
      logic        ok;
   } done_t;

   wr_t   wq[$];
   done_t dq[$];

   int n_chk = 0;
   int n_fail = 0;
   bit finished = 1'b0;

   logic [15:0] m_st   [N];
   logic [15:0] m_len  [N];
   logic [31:0] m_addr [N];
   int          m_idx = 0;

   task automatic chk(input bit good, input string tag, input logic [63:0] act,
                      input logic [63:0] exp);
      n_chk++;
      if (!good) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // monitor: pops predictions as results appear
   always @(negedge clk) begin
      if (rst_n && !finished) begin
         if (buf_we) begin
            if (wq.size() == 0) begin
               chk(1'b0, "R3 unexpected buffer write", {buf_addr, buf_data}, 0);
            end else begin
               wr_t e;
               e = wq.pop_front();
               chk(buf_addr == e.a && buf_data == e.d, "R3 buffer write",
                   {buf_addr, buf_data}, {e.a, e.d});
            end
         end
         if (frame_done) begin
            if (dq.size() == 0) begin
               chk(1'b0, "R10 unexpected completion", done_idx, 0);
            end else begin
               done_t e;
               e = dq.pop_front();
               chk(done_idx == e.idx, "R4 R5 completed slot", done_idx, e.idx);
               chk(done_status == e.st, "R2 R7 R8 R9 status", done_status, e.st);
               chk(done_len == e.len, "R6 R8 length", done_len, e.len);
               chk(done_ok == e.ok, "R6 accept flag", done_ok, e.ok);
            end
         end
      end
   end

   task automatic sw_write(input int idx, input logic [15:0] st, input logic [15:0] len,
                           input logic [31:0] addr);
      @(negedge clk);
      sw_we = 1'b1; sw_idx = 2'(idx); sw_status = st; sw_len = len; sw_addr = addr;
      @(negedge clk);
      sw_we = 1'b0;
      m_st[idx] = st; m_len[idx] = len; m_addr[idx] = addr;
   endtask

   task automatic kick();
      @(negedge clk);
      sw_kick = 1'b1;
      @(negedge clk);
      sw_kick = 1'b0;
   endtask

   task automatic check_rd(input int idx, input string tag);
      @(negedge clk);
      sw_rd_idx = 2'(idx);
      #1;
      chk(sw_rd_status == m_st[idx], tag, sw_rd_status, m_st[idx]);
      chk(sw_rd_len == m_len[idx], tag, sw_rd_len, m_len[idx]);
      chk(sw_rd_addr == m_addr[idx], tag, sw_rd_addr, m_addr[idx]);
   endtask

   // driver: predicts, then drives one frame
   task automatic send_frame(input int n, input bit crc, input bit al, input bit ov,
                             input int seed);
      int idx;
      idx = m_idx;
      if (m_st[idx][15]) begin
         int cap;
         int stored;
         logic [15:0] st;
         done_t e;
         cap = int'(m_len[idx]);
         for (int i = 0; i < n; i++)
            if (i < cap) wq.push_back('{a: m_addr[idx] + 32'(i), d: 8'(i * 7 + seed)});
         stored = (n > cap) ? cap : n;
         st = 16'h0800;
         st[13] = m_st[idx][13];
         st[5]  = (n > 1518);
         st[4]  = al;
         st[2]  = crc;
         st[1]  = ov;
         st[0]  = (n > cap);
         e.idx = 2'(idx);
         e.st  = st;
         e.len = 16'(stored);
         e.ok  = (st[5:0] == 6'b0) && (stored - 4 > 14);
         dq.push_back(e);
         m_st[idx]  = st;
         m_len[idx] = 16'(stored);
         m_idx = (st[13] || idx == N - 1) ? 0 : idx + 1;
      end
      for (int i = 0; i < n; i++) begin
         @(negedge clk);
         rx_valid = 1'b1;
         rx_data  = 8'(i * 7 + seed);
         rx_eof   = (i == n - 1);
         rx_err_crc   = (i == n - 1) && crc;
         rx_err_align = (i == n - 1) && al;
         rx_err_ovr   = (i == n - 1) && ov;
      end
      @(negedge clk);
      rx_valid = 1'b0; rx_eof = 1'b0;
      rx_err_crc = 1'b0; rx_err_align = 1'b0; rx_err_ovr = 1'b0;
      repeat (3) @(negedge clk);
      chk(wq.size() == 0, "R3 all predicted writes seen", wq.size(), 0);
      chk(dq.size() == 0, "R2 predicted completion seen", dq.size(), 0);
   endtask

   task automatic finish_run();
      if (!finished) begin
         finished = 1'b1;
         $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
         $finish;
      end
   endtask

   initial begin
      repeat (200000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=1 expected=0");
      finish_run();
   end

   initial begin
      for (int i = 0; i < N; i++) begin
         m_st[i] = '0; m_len[i] = '0; m_addr[i] = '0;
      end
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      #1;
      // R1 reset state
      chk(buf_we == 1'b0, "R1 buf_we after reset", buf_we, 0);
      chk(frame_done == 1'b0, "R1 frame_done after reset", frame_done, 0);
      chk(nobuf_evt == 1'b0, "R1 nobuf_evt after reset", nobuf_evt, 0);
      check_rd(0, "R1 descriptor cleared");
      check_rd(3, "R1 descriptor cleared");

      // R11 software arms the ring, WRAP on the final slot
      for (int i = 0; i < N; i++)
         sw_write(i, (i == N - 1) ? 16'hA000 : 16'h8000, 16'd64, 32'h1000 + 32'(i) * 32'h100);
      check_rd(3, "R11 descriptor readback");
      check_rd(1, "R11 descriptor readback");

      // R2 R3 R4 R6 good frame in slot 0
      send_frame(60, 0, 0, 0, 3);
      check_rd(0, "R2 written-back descriptor");
      // R6 boundary: length 18 is rejected
      send_frame(18, 0, 0, 0, 11);
      // R7 CRC error in slot 2, length 19
      send_frame(19, 1, 0, 0, 5);
      // R5 R6 length 19 accepted in the WRAP slot
      send_frame(19, 0, 0, 0, 9);
      check_rd(3, "R5 WRAP kept in written status");

      // R10 slot 0 still owned by software: drop
      send_frame(30, 0, 0, 0, 1);
      chk(nobuf_evt == 1'b1, "R10 no-buffer event raised", nobuf_evt, 1);
      check_rd(0, "R10 dropped frame left slot untouched");
      sw_write(0, 16'h8000, 16'd64, 32'h1000);
      @(negedge clk);
      chk(nobuf_evt == 1'b1, "R10 event sticky before kick", nobuf_evt, 1);
      kick();
      chk(nobuf_evt == 1'b0, "R10 event cleared by kick", nobuf_evt, 0);

      // R8 R7 truncation plus alignment and overrun in slot 0 (index held)
      send_frame(80, 0, 1, 1, 2);
      check_rd(0, "R8 truncated length stored");

      // R9 R5 overlong frame in slot 1 re-armed as the ring's end
      sw_write(1, 16'hA000, 16'd2000, 32'h4000);
      send_frame(1520, 0, 0, 0, 4);

      // R5 ring restarted at slot 0; single-byte frame
      sw_write(0, 16'h8000, 16'd64, 32'h2000);
      send_frame(1, 0, 0, 0, 6);
      check_rd(0, "R6 single byte length");

      finish_run();
   end

endmodule